// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block steps a small multi-cycle processor through its instruction cycle and drives the datapath enables for each step. Every instruction begins with a fetch cycle and then a decode cycle. The decode cycle reads the 4-bit opcode from the instruction register and picks the execute path. Arithmetic instructions take one execute cycle. A store takes an address cycle that also writes memory. A load takes an address cycle and then a separate read cycle that writes the memory data into a register. When an instruction completes, the sequencer returns to fetch.

The outputs depend only on registered state. That state is the 3-bit state code, plus an opcode copy that is captured during decode. An external datapath can therefore use the enables directly in the same cycle. The current state code is exported for observation.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While the synchronous active-high reset is high, every enable output is low and `alu_sel_o` is 00. The clock edge that samples reset high puts the state at code 0.
- R2: In state 0 (fetch), `pc_step_o`, `mem_rd_o` and `instr_latch_o` are high and every other enable is low. The next state is always 1.
- R3: In state 1 (decode), no enable is asserted. The opcode sampled at the end of this cycle picks the next state: 0001 (add) leads to 2, 0010 (subtract) leads to 3, 0011 (load) and 0100 (store) lead to 4, and 0000 (no-op) leads back to 0.
- R4: The undefined opcodes 0101 through 1111 act as a no-op. Decode goes straight back to state 0 and no datapath enable is asserted for them.
- R5: In state 2 (add), `alu_sel_o` is 00 and `rf_we_o` is high with every other enable low. The next state is 0.
- R6: In state 3 (subtract), `alu_sel_o` is 01 and `rf_we_o` is high with every other enable low. The next state is 0. `alu_sel_o` is 00 in every state other than 3.
- R7: In state 4 for a store, only `mem_wr_o` is high. The next state is 0.
- R8: In state 4 for a load, no enable is asserted (address setup). The next state is 5.
- R9: In state 5 (load read), `mem_rd_o`, `rf_src_mem_o` and `rf_we_o` are high with every other enable low. The next state is 0.
- R10: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.
- R11: The opcode is captured during decode. A change on `opcode_i` after decode has no effect on the path or on the enables of the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | OPC_W (4) | Opcode field from the instruction register |
| pc_step_o | output | 1 | Advance the program counter |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| alu_sel_o | output | ALU_W (2) | ALU function: 00 add, 01 subtract |
| rf_we_o | output | 1 | Register file write enable |
| rf_src_mem_o | output | 1 | Register write data comes from memory |
| instr_latch_o | output | 1 | Load the instruction register |
| state_o | output | 3 | Current state code |

## Verification
Each of the five defined opcodes is issued on its own. The resulting state walk and the enables in every cycle show whether decode picks the right branch. They also show whether states 2 and 3 differ only in the ALU select, and whether the shared state 4 separates a store from the first half of a load. All eleven undefined opcodes are swept to confirm that they cannot reach an execute state. The opcode input is switched between load and store while state 4 is active, which shows whether the captured copy or the live input steers the path. A reset asserted in the middle of a load shows that the enables drop at once and that the state returns to fetch on the next edge.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   localparam int unsigned ST_W   = 3;
   localparam int unsigned NUM_ST = 6;

   localparam int unsigned OP_NOP   = 0;
   localparam int unsigned OP_ADD   = 1;
   localparam int unsigned OP_SUB   = 2;
   localparam int unsigned OP_LOAD  = 3;
   localparam int unsigned OP_STORE = 4;

   localparam int unsigned ALU_ADD = 0;
   localparam int unsigned ALU_SUB = 1;

   typedef enum logic [ST_W-1:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_ADD    = 3'd2,
      ST_SUB    = 3'd3,
      ST_MADDR  = 3'd4,
      ST_MREAD  = 3'd5
   } mc_state_e;

   typedef struct packed {
      logic pc_step;
      logic mem_rd;
      logic mem_wr;
      logic rf_we;
      logic rf_src_mem;
      logic instr_latch;
   } mc_strobe_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
   import mc_ctrl_pkg::*;
#(
   parameter int unsigned OPC_W = 4
) (
   input  mc_state_e        state_i,
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [OPC_W-1:0] op_q_i,
   output mc_state_e        next_o
);

   logic live_add, live_sub, live_mem, held_load;

   assign live_add  = (opcode_i == OPC_W'(OP_ADD));
   assign live_sub  = (opcode_i == OPC_W'(OP_SUB));
   assign live_mem  = (opcode_i == OPC_W'(OP_LOAD)) || (opcode_i == OPC_W'(OP_STORE));
   assign held_load = (op_q_i == OPC_W'(OP_LOAD));

   always_comb begin
      next_o = ST_FETCH;
      case (state_i)
         ST_FETCH:  next_o = ST_DECODE;
         ST_DECODE: begin
            if (live_add)      next_o = ST_ADD;
            else if (live_sub) next_o = ST_SUB;
            else if (live_mem) next_o = ST_MADDR;
            else               next_o = ST_FETCH;
         end
         ST_MADDR:  next_o = held_load ? ST_MREAD : ST_FETCH;
         default:   next_o = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_outdec.sv
module mc_ctrl_outdec
   import mc_ctrl_pkg::*;
#(
   parameter int unsigned OPC_W = 4,
   parameter int unsigned ALU_W = 2
) (
   input  logic             rst_i,
   input  mc_state_e        state_i,
   input  logic [OPC_W-1:0] op_q_i,
   output mc_strobe_t       strobe_o,
   output logic [ALU_W-1:0] alu_sel_o
);

   logic [ST_W-1:0]   st_raw;
   logic [NUM_ST-1:0] hit;
   logic              held_store;
   logic              run;

   assign st_raw     = state_i;
   assign held_store = (op_q_i == OPC_W'(OP_STORE));
   assign run        = !rst_i;

   for (genvar s = 0; s < NUM_ST; s++) begin : g_hit
      assign hit[s] = (st_raw == ST_W'(s));
   end

   always_comb begin
      strobe_o.pc_step     = run & hit[ST_FETCH];
      strobe_o.instr_latch = run & hit[ST_FETCH];
      strobe_o.mem_rd      = run & (hit[ST_FETCH] | hit[ST_MREAD]);
      strobe_o.mem_wr      = run & hit[ST_MADDR] & held_store;
      strobe_o.rf_we       = run & (hit[ST_ADD] | hit[ST_SUB] | hit[ST_MREAD]);
      strobe_o.rf_src_mem  = run & hit[ST_MREAD];
      alu_sel_o = (run & hit[ST_SUB]) ? ALU_W'(ALU_SUB) : ALU_W'(ALU_ADD);
   end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
   import mc_ctrl_pkg::*;
#(
   parameter int unsigned OPC_W = 4,
   parameter int unsigned ALU_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [OPC_W-1:0] opcode_i,
   output logic             pc_step_o,
   output logic             mem_rd_o,
   output logic             mem_wr_o,
   output logic [ALU_W-1:0] alu_sel_o,
   output logic             rf_we_o,
   output logic             rf_src_mem_o,
   output logic             instr_latch_o,
   output logic [ST_W-1:0]  state_o
);

   if (OPC_W < 3) begin : g_bad_opc_w
      $error("mc_ctrl_seq: OPC_W must hold opcode value 4");
   end
   if (ALU_W < 1) begin : g_bad_alu_w
      $error("mc_ctrl_seq: ALU_W must be at least 1");
   end

   mc_state_e        state_q, state_d;
   logic [OPC_W-1:0] op_q;
   mc_strobe_t       strobe;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_FETCH;
         op_q    <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_DECODE) op_q <= opcode_i;
      end
   end

   mc_ctrl_next #(.OPC_W(OPC_W)) u_next (
      .state_i  (state_q),
      .opcode_i (opcode_i),
      .op_q_i   (op_q),
      .next_o   (state_d)
   );

   mc_ctrl_outdec #(.OPC_W(OPC_W), .ALU_W(ALU_W)) u_outdec (
      .rst_i     (rst_i),
      .state_i   (state_q),
      .op_q_i    (op_q),
      .strobe_o  (strobe),
      .alu_sel_o (alu_sel_o)
   );

   assign pc_step_o     = strobe.pc_step;
   assign mem_rd_o      = strobe.mem_rd;
   assign mem_wr_o      = strobe.mem_wr;
   assign rf_we_o       = strobe.rf_we;
   assign rf_src_mem_o  = strobe.rf_src_mem;
   assign instr_latch_o = strobe.instr_latch;
   assign state_o       = state_q;

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk
   import mc_ctrl_pkg::*;
#(
   parameter int unsigned OPC_W = 4,
   parameter int unsigned ALU_W = 2
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [OPC_W-1:0] opcode_i,
   input logic             pc_step_o,
   input logic             mem_rd_o,
   input logic             mem_wr_o,
   input logic [ALU_W-1:0] alu_sel_o,
   input logic             rf_we_o,
   input logic             rf_src_mem_o,
   input logic             instr_latch_o,
   input logic [ST_W-1:0]  state_o
);

   always_comb begin
      if (rst_i) begin
         a_r1_quiet_in_reset: assert (!pc_step_o && !mem_rd_o && !mem_wr_o && !rf_we_o
                                      && !rf_src_mem_o && !instr_latch_o && alu_sel_o == '0);
      end
   end

   a_r1_reset_to_fetch: assert property (@(posedge clk_i) rst_i |=> state_o == 3'd0);

   a_r2_fetch_strobes: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd0 |-> pc_step_o && mem_rd_o && instr_latch_o && !mem_wr_o && !rf_we_o);

   a_r2_fetch_next: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd0 |=> state_o == 3'd1);

   a_r3_decode_add: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd1 && opcode_i == OPC_W'(OP_ADD) |=> state_o == 3'd2);

   a_r3_decode_sub: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd1 && opcode_i == OPC_W'(OP_SUB) |=> state_o == 3'd3);

   a_r4_undef_back: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd1 && opcode_i > OPC_W'(OP_STORE) |=> state_o == 3'd0);

   a_r5_add_out: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd2 |-> rf_we_o && alu_sel_o == ALU_W'(ALU_ADD) && !mem_rd_o && !mem_wr_o);

   a_r6_sub_out: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd3 |-> rf_we_o && alu_sel_o == ALU_W'(ALU_SUB) && !mem_rd_o && !mem_wr_o);

   a_r7_store_done: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd4 && mem_wr_o |=> state_o == 3'd0);

   a_r8_load_path: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd1 && opcode_i == OPC_W'(OP_LOAD) |=> state_o == 3'd4 ##1 state_o == 3'd5);

   a_r9_read_out: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o == 3'd5 |-> mem_rd_o && rf_src_mem_o && rf_we_o && !mem_wr_o);

   a_r10_mem_excl: assert property (@(posedge clk_i) disable iff (rst_i)
      !(mem_rd_o && mem_wr_o));

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk #(.OPC_W(OPC_W), .ALU_W(ALU_W)) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .opcode_i      (opcode_i),
   .pc_step_o     (pc_step_o),
   .mem_rd_o      (mem_rd_o),
   .mem_wr_o      (mem_wr_o),
   .alu_sel_o     (alu_sel_o),
   .rf_we_o       (rf_we_o),
   .rf_src_mem_o  (rf_src_mem_o),
   .instr_latch_o (instr_latch_o),
   .state_o       (state_o)
);

// File: tb/test_mc_ctrl_seq.sv
module test_mc_ctrl_seq;

   // enable vector order: pc, rd, wr, alu[1:0], we, src, latch
   localparam logic [7:0] E_NONE  = 8'b0000_0000;
   localparam logic [7:0] E_FETCH = 8'b1100_0001;
   localparam logic [7:0] E_ADD   = 8'b0000_0100;
   localparam logic [7:0] E_SUB   = 8'b0000_1100;
   localparam logic [7:0] E_STW   = 8'b0010_0000;
   localparam logic [7:0] E_LDRD  = 8'b0100_0110;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] opcode = 4'd0;
   logic       pc_step, mem_rd, mem_wr, rf_we, rf_src_mem, instr_latch;
   logic [1:0] alu_sel;
   logic [2:0] state;
   int         n_run = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   mc_ctrl_seq i_mc_ctrl_seq (
      .clk_i         (clk),
      .rst_i         (rst),
      .opcode_i      (opcode),
      .pc_step_o     (pc_step),
      .mem_rd_o      (mem_rd),
      .mem_wr_o      (mem_wr),
      .alu_sel_o     (alu_sel),
      .rf_we_o       (rf_we),
      .rf_src_mem_o  (rf_src_mem),
      .instr_latch_o (instr_latch),
      .state_o       (state)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [2:0] es, input logic [7:0] eo);
      logic [7:0] got;
      got = {pc_step, mem_rd, mem_wr, alu_sel, rf_we, rf_src_mem, instr_latch};
      n_run++;
      if (state !== es || got !== eo) begin
         n_fail++;
         $display("FAIL %s: state=%0d enables=%b expected state=%0d enables=%b",
                  req, state, got, es, eo);
      end
      n_run++;
      if (mem_rd === 1'b1 && mem_wr === 1'b1) begin
         n_fail++;
         $display("FAIL R10: rd=%b wr=%b expected not both high", mem_rd, mem_wr);
      end
   endtask

   // from fetch, present an opcode and move into decode
   task automatic issue(input logic [3:0] op);
      chk("R2", 3'd0, E_FETCH);
      opcode = op;
      step();
      chk("R3", 3'd1, E_NONE);
   endtask

   task automatic t_nop();
      issue(4'd0);
      step(); chk("R3", 3'd0, E_FETCH);
   endtask

   task automatic t_add();
      issue(4'd1);
      step(); chk("R5", 3'd2, E_ADD);
      step(); chk("R5", 3'd0, E_FETCH);
   endtask

   task automatic t_sub();
      issue(4'd2);
      step(); chk("R6", 3'd3, E_SUB);
      step(); chk("R6", 3'd0, E_FETCH);
   endtask

   task automatic t_store();
      issue(4'd4);
      step(); chk("R7", 3'd4, E_STW);
      step(); chk("R7", 3'd0, E_FETCH);
   endtask

   task automatic t_load();
      issue(4'd3);
      step(); chk("R8", 3'd4, E_NONE);
      step(); chk("R9", 3'd5, E_LDRD);
      step(); chk("R9", 3'd0, E_FETCH);
   endtask

   task automatic t_undef();
      for (int op = 5; op < 16; op++) begin
         issue(4'(op));
         step(); chk("R4", 3'd0, E_FETCH);
      end
   endtask

   task automatic t_latch();
      issue(4'd3);
      step(); opcode = 4'd4; chk("R11", 3'd4, E_NONE);
      step(); chk("R11", 3'd5, E_LDRD);
      step(); chk("R11", 3'd0, E_FETCH);
      issue(4'd4);
      step(); opcode = 4'd3; chk("R11", 3'd4, E_STW);
      step(); chk("R11", 3'd0, E_FETCH);
   endtask

   task automatic t_reset_mid();
      issue(4'd3);
      step(); step();
      rst = 1'b1;
      #0.1 chk("R1", 3'd5, E_NONE);
      step(); chk("R1", 3'd0, E_NONE);
      rst = 1'b0;
      #0.1 chk("R2", 3'd0, E_FETCH);
   endtask

   initial begin
      #(4 * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      opcode = 4'd0;
      repeat (3) step();
      chk("R1", 3'd0, E_NONE);
      rst = 1'b0;
      #0.1;
      t_nop();
      t_add();
      t_sub();
      t_store();
      t_load();
      t_undef();
      t_latch();
      t_add();
      t_reset_mid();
      t_load();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule